// File: doc/BRIEF.md
# Platform Interrupt Router

This block gathers a set of external interrupt inputs and forwards them to a few target contexts. Each context stands for one privilege mode of one hart. Every source carries a programmable priority and a trigger mode, either level or edge. Every context carries its own enable mask, its own priority threshold and its own claim/complete register.

A context's interrupt line is high whenever at least one source meets all three conditions: it is pending, it is enabled for that context, and its priority is strictly above that context's threshold. Software reads the context's claim register to learn which source to serve, and that read also takes the source out of arbitration. Writing the same source ID back to the claim register later releases the source.

Edge sources remember one further rising edge that arrives while they are pending or in service, so that an early completion does not drop an event. All configuration goes through a simple word-wide register bus. Read data appears on the cycle after the request.

Top module: `intr_router`

## Requirements
- R1: After reset, every priority, trigger, enable and threshold register reads 0, a claim read returns 0, and every `ctx_irq` bit is low.
- R2: The priority register of source s is at byte offset s*4. A written value above MAX_PRIO is stored as MAX_PRIO, and smaller values are stored unchanged.
- R3: The enable bit of source s for context c is bit s&31 of the word at 0x2000 + c*0x80 + (s>>5)*4. The threshold of context c is at 0x200000 + c*0x1000. `ctx_irq[c]` is high exactly when some source is pending, enabled for c, and has a priority strictly greater than the threshold of c.
- R4: A read of 0x200004 + c*0x1000 returns, on the next cycle, the eligible source of context c with the highest priority. Ties go to the lowest ID. The read returns 0 when no source is eligible.
- R5: A claim read clears the pending state of the returned source. That source raises no request until its ID is written to a claim/complete register.
- R6: In level mode (bit s of the word at 0x1080 + (s>>5)*4 is 0), a source whose input is still high after its completion becomes pending again.
- R7: In edge mode (that trigger bit is 1), a rising edge makes an idle source pending. One further edge that arrives while the source is pending or claimed is kept and raised after completion. Extra edges beyond that one merge into it.
- R8: A completion write naming a source that is not claimed changes nothing.
- R9: Reads of unmapped offsets return 0. Writes to them change no register.
- R10: Source 0 is reserved: its priority, trigger and enable bits read 0, and it never interrupts a context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Synchronous interrupt inputs, bit s is source s |
| bus_req | input | 1 | Register access request, one per cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address; the low two bits are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read and 0 otherwise |
| ctx_irq | output | NUM_CTX | Interrupt line of each context |

## Verification
A source input that changes before a clock edge becomes pending at that edge. From that edge on, the matching `ctx_irq` bit is high, so a context line answers one edge after its input. A claim or register read returns data one edge after the request. Its pending and in-service effects take hold at that same edge. A completion clears the in-service state at its write edge, and a level source that is still high becomes pending one edge after that. For this reason the directed sequences leave two idle cycles after each completion before they read the claim register. The bench model advances at each rising edge from the same inputs and holds the expected line and read-data values. Both are compared on the following falling edge, where every register on the path has already settled.

// File: rtl/intr_pkg.sv
package intr_pkg;
   localparam logic [31:0] TRIG_BASE  = 32'h0000_1080;
   localparam logic [31:0] EN_BASE    = 32'h0000_2000;
   localparam int          EN_STRIDE  = 32'h80;
   localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
   localparam int          CTX_STRIDE = 32'h1000;
   localparam logic [31:0] CLAIM_OFS  = 32'h4;

   typedef enum logic {TRIG_LEVEL = 1'b0, TRIG_EDGE = 1'b1} trig_e;

   // saturate a written priority or threshold to the configured ceiling
   function automatic logic [31:0] clamp_prio(input logic [31:0] v, input int unsigned mx);
      return (v > mx) ? 32'(mx) : v;
   endfunction
endpackage

// File: rtl/intr_gateway.sv
module intr_gateway
   import intr_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  src,
   input  trig_e mode,
   input  logic  claim,
   input  logic  complete,
   output logic  pend,
   output logic  busy
);
   logic prev_q, latch_q;
   logic rise, free;

   assign rise = src & ~prev_q;
   assign free = ~pend & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         latch_q <= 1'b0;
         pend    <= 1'b0;
         busy    <= 1'b0;
      end else begin
         prev_q <= src;
         if (claim) begin
            pend <= 1'b0;
            busy <= 1'b1;
         end else if (complete && busy) begin
            busy <= 1'b0;
         end
         if (mode == TRIG_LEVEL) begin
            latch_q <= 1'b0;
            if (free && src) pend <= 1'b1;
         end else begin
            if (free && (rise || latch_q)) begin
               pend    <= 1'b1;
               latch_q <= rise & latch_q;
            end else if (rise) begin
               latch_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 3,
   localparam int ID_W   = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0]        pend,
   input  logic [NUM_SRC-1:0]        en,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   input  logic [PRIO_W-1:0]         thr,
   output logic [ID_W-1:0]           win_id,
   output logic                      win_ok
);
   logic [PRIO_W-1:0] best_p;
   logic [PRIO_W-1:0] p;

   // strict comparison keeps the lowest ID among equal priorities
   always_comb begin
      win_id = '0;
      win_ok = 1'b0;
      best_p = '0;
      p      = '0;
      for (int s = 0; s < NUM_SRC; s++) begin
         p = prio_flat[s*PRIO_W +: PRIO_W];
         if (pend[s] && en[s] && (p > thr) && (!win_ok || p > best_p)) begin
            win_ok = 1'b1;
            best_p = p;
            win_id = ID_W'(s);
         end
      end
   end
endmodule

// File: rtl/intr_router.sv
module intr_router
   import intr_pkg::*;
#(
   parameter int NUM_SRC  = 32,
   parameter int NUM_CTX  = 2,
   parameter int PRIO_W   = 3,
   parameter int MAX_PRIO = 7,
   parameter int ADDR_W   = 26
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               bus_req,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic [NUM_CTX-1:0] ctx_irq
);
   localparam int NW   = (NUM_SRC + 31) / 32;
   localparam int ID_W = $clog2(NUM_SRC);

   if (NUM_SRC < 2 || NUM_SRC > 1024) begin : g_bad_src
      $fatal(1, "NUM_SRC must lie in 2..1024");
   end
   if (MAX_PRIO < 1 || MAX_PRIO >= (1 << PRIO_W)) begin : g_bad_prio
      $fatal(1, "MAX_PRIO must fit in PRIO_W bits");
   end
   if (NUM_CTX < 1 || NUM_CTX > 32) begin : g_bad_ctx
      $fatal(1, "NUM_CTX must lie in 1..32");
   end
   if (ADDR_W < 22 || ADDR_W > 32 ||
       (ADDR_W < 32 && 64'(CTX_BASE) + 64'(NUM_CTX * CTX_STRIDE) > (64'd1 << ADDR_W))) begin : g_bad_addr
      $fatal(1, "ADDR_W too narrow for the context window");
   end

   function automatic logic [NW*32-1:0] mk_mask();
      logic [NW*32-1:0] m;
      m = '0;
      for (int i = 1; i < NUM_SRC; i++) m[i] = 1'b1;
      return m;
   endfunction
   localparam logic [NW*32-1:0] SRC_MASK = mk_mask();

   // configuration state
   logic [PRIO_W-1:0] prio_q [NUM_SRC];
   logic [NW*32-1:0]  trig_q;
   logic [NW*32-1:0]  en_q   [NUM_CTX];
   logic [PRIO_W-1:0] thr_q  [NUM_CTX];
   logic [31:0]       rdata_q;

   // gateway and arbiter wiring
   logic [NUM_SRC-1:0]        pend_vec, busy_vec, clm_vec, cmp_vec;
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic [ID_W-1:0]           win_id [NUM_CTX];
   logic [NUM_CTX-1:0]        win_ok;

   // address decode
   logic        rd, wr;
   logic [31:0] a, p_idx, t_idx, e_ctx, e_w, c_idx, c_ofs;
   logic        is_prio, is_trig, is_en, is_ctx, is_thr, is_clm;
   logic [31:0] rd_val;

   assign rd = bus_req & ~bus_we;
   assign wr = bus_req & bus_we;

   always_comb begin
      a       = 32'(bus_addr);
      p_idx   = a >> 2;
      is_prio = a < 32'(NUM_SRC * 4);
      t_idx   = (a - TRIG_BASE) >> 2;
      is_trig = (a >= TRIG_BASE) && (a < TRIG_BASE + 32'(NW * 4));
      e_ctx   = (a - EN_BASE) >> 7;
      e_w     = ((a - EN_BASE) >> 2) & 32'd31;
      is_en   = (a >= EN_BASE) && (a < EN_BASE + 32'(NUM_CTX * EN_STRIDE)) && (e_w < 32'(NW));
      c_idx   = (a - CTX_BASE) >> 12;
      c_ofs   = (a - CTX_BASE) & 32'hFFC;
      is_ctx  = (a >= CTX_BASE) && (a < CTX_BASE + 32'(NUM_CTX * CTX_STRIDE));
      is_thr  = is_ctx && (c_ofs == 32'd0);
      is_clm  = is_ctx && (c_ofs == CLAIM_OFS);
   end

   // read mux
   always_comb begin
      rd_val = '0;
      if (is_prio) begin
         for (int s = 0; s < NUM_SRC; s++)
            if (p_idx == 32'(s)) rd_val = 32'(prio_q[s]);
      end
      if (is_trig) begin
         for (int w = 0; w < NW; w++)
            if (t_idx == 32'(w)) rd_val = trig_q[w*32 +: 32];
      end
      if (is_en) begin
         for (int c = 0; c < NUM_CTX; c++)
            for (int w = 0; w < NW; w++)
               if (e_ctx == 32'(c) && e_w == 32'(w)) rd_val = en_q[c][w*32 +: 32];
      end
      for (int c = 0; c < NUM_CTX; c++) begin
         if (is_thr && c_idx == 32'(c)) rd_val = 32'(thr_q[c]);
         if (is_clm && c_idx == 32'(c)) rd_val = 32'(win_id[c]);
      end
   end

   // claim and completion strobes toward the gateways
   always_comb begin
      clm_vec = '0;
      cmp_vec = '0;
      for (int c = 0; c < NUM_CTX; c++)
         if (rd && is_clm && c_idx == 32'(c) && win_ok[c]) clm_vec[win_id[c]] = 1'b1;
      for (int s = 1; s < NUM_SRC; s++)
         cmp_vec[s] = wr && is_clm && (bus_wdata == 32'(s));
   end

   // register writes and read data
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
         for (int c = 0; c < NUM_CTX; c++) begin
            en_q[c]  <= '0;
            thr_q[c] <= '0;
         end
         trig_q  <= '0;
         rdata_q <= '0;
      end else begin
         rdata_q <= rd ? rd_val : 32'd0;
         if (wr) begin
            for (int s = 1; s < NUM_SRC; s++)
               if (is_prio && p_idx == 32'(s))
                  prio_q[s] <= PRIO_W'(clamp_prio(bus_wdata, MAX_PRIO));
            for (int w = 0; w < NW; w++)
               if (is_trig && t_idx == 32'(w))
                  trig_q[w*32 +: 32] <= bus_wdata & SRC_MASK[w*32 +: 32];
            for (int c = 0; c < NUM_CTX; c++) begin
               for (int w = 0; w < NW; w++)
                  if (is_en && e_ctx == 32'(c) && e_w == 32'(w))
                     en_q[c][w*32 +: 32] <= bus_wdata & SRC_MASK[w*32 +: 32];
               if (is_thr && c_idx == 32'(c))
                  thr_q[c] <= PRIO_W'(clamp_prio(bus_wdata, MAX_PRIO));
            end
         end
      end
   end

   assign bus_rdata = rdata_q;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
      if (s == 0) begin : g_rsv
         assign pend_vec[s] = 1'b0;
         assign busy_vec[s] = 1'b0;
      end else begin : g_gw
         intr_gateway u_gw (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (src_in[s]),
            .mode     (trig_e'(trig_q[s])),
            .claim    (clm_vec[s]),
            .complete (cmp_vec[s]),
            .pend     (pend_vec[s]),
            .busy     (busy_vec[s])
         );
      end
   end

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      intr_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
         .pend      (pend_vec),
         .en        (en_q[c][NUM_SRC-1:0]),
         .prio_flat (prio_flat),
         .thr       (thr_q[c]),
         .win_id    (win_id[c]),
         .win_ok    (win_ok[c])
      );
      assign ctx_irq[c] = win_ok[c];
   end

   logic unused_bits;
   assign unused_bits = ^{src_in[0], trig_q[0], clm_vec[0], cmp_vec[0]};
endmodule

// File: rtl/intr_router_chk.sv
module intr_router_chk
   import intr_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int NUM_CTX = 2,
   parameter int ADDR_W  = 26
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_req,
   input logic               bus_we,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_rdata,
   input logic [NUM_CTX-1:0] ctx_irq,
   input logic [NUM_SRC-1:0] pend_vec,
   input logic [NUM_SRC-1:0] busy_vec,
   input logic [NUM_SRC-1:0] clm_vec,
   input logic [NUM_SRC-1:0] cmp_vec
);
   // R4: at most one source is taken by any single claim read
   p_one_claim_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(clm_vec));

   for (genvar s = 1; s < NUM_SRC; s++) begin : g_s
      // R5: the claimed source leaves arbitration and enters service
      p_claim_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
         clm_vec[s] |=> (busy_vec[s] && !pend_vec[s]));
      // R5: a source in service never shows a request
      p_busy_holds_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
         busy_vec[s] |-> !pend_vec[s]);
      // R8: a completion for a pending, unclaimed source leaves it pending
      p_stray_complete_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (cmp_vec[s] && pend_vec[s]) |=> pend_vec[s]);
   end

   for (genvar c = 0; c < NUM_CTX; c++) begin : g_c
      localparam logic [31:0] CLM_A = CTX_BASE + 32'(c * CTX_STRIDE) + CLAIM_OFS;
      // R4: claim with the line low returns 0 next cycle
      p_empty_claim_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_req && !bus_we && 32'(bus_addr) == CLM_A && !ctx_irq[c]) |=> (bus_rdata == 32'd0));
      // R4: claim with the line high returns a real source ID
      p_claim_has_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_req && !bus_we && 32'(bus_addr) == CLM_A && ctx_irq[c]) |=>
         (bus_rdata != 32'd0 && bus_rdata < 32'(NUM_SRC)));
   end
endmodule

bind intr_router intr_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .ctx_irq   (ctx_irq),
   .pend_vec  (pend_vec),
   .busy_vec  (busy_vec),
   .clm_vec   (clm_vec),
   .cmp_vec   (cmp_vec)
);

// File: tb/intr_router_tb_top.sv
module intr_router_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 32;
   localparam int NC = 2;
   localparam int PW = 3;
   localparam int MP = 7;
   localparam int AW = 26;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic          req = 1'b0, we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NC-1:0] irq;

   intr_router #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(PW), .MAX_PRIO(MP), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_in(src), .bus_req(req), .bus_we(we),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .ctx_irq(irq));

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_prio [NS];
   int m_thr  [NC];
   bit m_trig [NS], m_pend [NS], m_busy [NS], m_latch [NS], m_prev [NS];
   bit m_en   [NC][NS];
   logic [31:0] m_rdata = '0;
   logic [NC-1:0] m_irq = '0;

   function automatic int pick(input int c);
      int best = 0, bp = 0;
      for (int s = 0; s < NS; s++)
         if (m_pend[s] && m_en[c][s] && m_prio[s] > m_thr[c] && m_prio[s] > bp) begin
            bp = m_prio[s];
            best = s;
         end
      return best;
   endfunction

   function automatic logic [31:0] peek(input logic [31:0] x);
      logic [31:0] v = '0;
      if (x < NS * 4) v = m_prio[x >> 2];
      else if (x >= 32'h1080 && x < 32'h1084) begin
         for (int s = 0; s < NS; s++) v[s] = m_trig[s];
      end else if (x >= 32'h2000 && x < 32'h2000 + NC * 32'h80) begin
         if (((x - 32'h2000) & 32'h7C) == 0)
            for (int s = 0; s < NS; s++) v[s] = m_en[(x - 32'h2000) >> 7][s];
      end else if (x >= 32'h200000 && x < 32'h200000 + NC * 32'h1000) begin
         if (((x - 32'h200000) & 32'hFFC) == 0) v = m_thr[(x - 32'h200000) >> 12];
         else if (((x - 32'h200000) & 32'hFFC) == 4) v = pick((x - 32'h200000) >> 12);
      end
      return v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NS; s++) begin
            m_prio[s] = 0; m_trig[s] = 0; m_pend[s] = 0;
            m_busy[s] = 0; m_latch[s] = 0; m_prev[s] = 0;
            for (int c = 0; c < NC; c++) m_en[c][s] = 0;
         end
         for (int c = 0; c < NC; c++) m_thr[c] = 0;
         m_rdata = '0;
         m_irq = '0;
      end else begin
         logic [31:0] x, rdv, ofs;
         int claim_id, cmp_id;
         bit in_ctx, free_old, rise;
         x = 32'(addr);
         in_ctx = x >= 32'h200000 && x < 32'h200000 + NC * 32'h1000;
         ofs = (x - 32'h200000) & 32'hFFC;
         rdv = '0; claim_id = 0; cmp_id = 0;
         if (req && !we) begin
            rdv = peek(x);
            if (in_ctx && ofs == 4) claim_id = int'(rdv);
         end
         if (req && we && in_ctx && ofs == 4 && wdata < NS) cmp_id = int'(wdata);
         for (int s = 1; s < NS; s++) begin
            free_old = !m_pend[s] && !m_busy[s];
            rise = src[s] && !m_prev[s];
            if (claim_id == s) begin m_pend[s] = 0; m_busy[s] = 1; end
            else if (cmp_id == s && m_busy[s]) m_busy[s] = 0;
            if (!m_trig[s]) begin
               m_latch[s] = 0;
               if (free_old && src[s]) m_pend[s] = 1;
            end else if (free_old && (rise || m_latch[s])) begin
               m_pend[s] = 1;
               m_latch[s] = rise && m_latch[s];
            end else if (rise) m_latch[s] = 1;
            m_prev[s] = src[s];
         end
         if (req && we) begin
            if (x < NS * 4 && (x >> 2) != 0) m_prio[x >> 2] = (wdata > MP) ? MP : int'(wdata);
            if (x >= 32'h1080 && x < 32'h1084)
               for (int s = 1; s < NS; s++) m_trig[s] = wdata[s];
            if (x >= 32'h2000 && x < 32'h2000 + NC * 32'h80 && ((x - 32'h2000) & 32'h7C) == 0)
               for (int s = 1; s < NS; s++) m_en[(x - 32'h2000) >> 7][s] = wdata[s];
            if (in_ctx && ofs == 0) m_thr[(x - 32'h200000) >> 12] = (wdata > MP) ? MP : int'(wdata);
         end
         m_rdata = rdv;
         for (int c = 0; c < NC; c++) m_irq[c] = (pick(c) != 0);
      end
   end

   // compared every cycle away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 model ctx_irq", 32'(irq), 32'(m_irq));
         chk("R4 model rdata", rdata, m_rdata);
      end
   end

   // ---------------- bus helpers ----------------
   function automatic logic [31:0] a_prio(input int s); return 32'(s * 4); endfunction
   function automatic logic [31:0] a_en(input int c); return 32'h2000 + 32'(c * 32'h80); endfunction
   function automatic logic [31:0] a_thr(input int c); return 32'h200000 + 32'(c * 32'h1000); endfunction
   function automatic logic [31:0] a_clm(input int c); return a_thr(c) + 32'd4; endfunction
   localparam logic [31:0] A_TRIG = 32'h1080;

   task automatic wr(input logic [31:0] a, input logic [31:0] d);
      req = 1'b1; we = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [31:0] a, output logic [31:0] v);
      req = 1'b1; we = 1'b0; addr = AW'(a);
      @(negedge clk);
      req = 1'b0;
      v = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog R1: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);
      // R1: reset values
      rd(a_prio(5), v); chk("R1 prio reset", v, 0);
      rd(a_en(0), v);   chk("R1 enable reset", v, 0);
      rd(a_thr(1), v);  chk("R1 threshold reset", v, 0);
      rd(A_TRIG, v);    chk("R1 trigger reset", v, 0);
      rd(a_clm(0), v);  chk("R1 claim reset", v, 0);
      chk("R1 lines low", 32'(irq), 0);
      // R2: saturation
      wr(a_prio(3), 20); rd(a_prio(3), v); chk("R2 clamp", v, 7);
      wr(a_prio(4), 6);  rd(a_prio(4), v); chk("R2 in range", v, 6);
      // R10: reserved source
      wr(a_prio(0), 5); rd(a_prio(0), v); chk("R10 prio0", v, 0);
      wr(a_en(0), 1);   rd(a_en(0), v);   chk("R10 enable bit0", v, 0);
      src[0] = 1'b1; idle(2);
      chk("R10 no line", 32'(irq), 0);
      rd(a_clm(0), v); chk("R10 claim", v, 0);
      // R9: unmapped space
      rd(32'h1000, v); chk("R9 unmapped read", v, 0);
      wr(32'h1000, 32'hFFFF_FFFF); rd(32'h1000, v); chk("R9 unmapped write", v, 0);
      wr(32'h3000, 32'hFFFF_FFFF); rd(a_en(1), v); chk("R9 enable untouched", v, 0);
      wr(32'h200008, 7); rd(a_thr(0), v); chk("R9 threshold untouched", v, 0);
      rd(32'h200008, v); chk("R9 ctx hole", v, 0);
      // configuration
      wr(a_prio(5), 4); wr(a_prio(9), 4); wr(a_prio(12), 6);
      wr(a_en(0), 32'h1229); rd(a_en(0), v); chk("R10 enable mask", v, 32'h1228);
      wr(a_thr(0), 3); rd(a_thr(0), v); chk("R3 threshold", v, 3);
      wr(A_TRIG, 32'h1001); rd(A_TRIG, v); chk("R7 trigger reg", v, 32'h1000);
      // R4 and R5: tie goes to lowest ID, claimed sources drop out
      src[5] = 1'b1; src[9] = 1'b1; idle(2);
      chk("R3 line up", 32'(irq), 1);
      rd(a_clm(0), v); chk("R4 tie low id", v, 5);
      rd(a_clm(0), v); chk("R5 next source", v, 9);
      rd(a_clm(0), v); chk("R4 empty claim", v, 0);
      chk("R5 line low in service", 32'(irq), 0);
      // R8: completion for a pending, unclaimed source
      src[12] = 1'b1; idle(1); src[12] = 1'b0; idle(1);
      chk("R7 edge pending", 32'(irq), 1);
      wr(a_clm(0), 12); idle(1);
      chk("R8 still pending", 32'(irq), 1);
      rd(a_clm(0), v); chk("R8 claim after stray", v, 12);
      wr(a_clm(0), 12); idle(1);
      // R6: level source re-pends after completion
      wr(a_clm(0), 5); idle(2);
      rd(a_clm(0), v); chk("R6 level again", v, 5);
      src[5] = 1'b0; wr(a_clm(0), 5); idle(2);
      rd(a_clm(0), v); chk("R6 low input", v, 0);
      // R3: strict threshold
      wr(a_clm(0), 9); idle(2);
      wr(a_prio(9), 3); idle(1);
      chk("R3 equal threshold", 32'(irq), 0);
      rd(a_clm(0), v); chk("R3 equal claim", v, 0);
      wr(a_prio(9), 4); idle(1);
      chk("R3 above threshold", 32'(irq), 1);
      rd(a_clm(0), v); chk("R3 above claim", v, 9);
      src[9] = 1'b0; wr(a_clm(0), 9); idle(2);
      // R7: edges during service
      src[12] = 1'b1; idle(1); src[12] = 1'b0; idle(1);
      rd(a_clm(0), v); chk("R7 first edge", v, 12);
      src[12] = 1'b1; idle(1); src[12] = 1'b0; idle(1);
      src[12] = 1'b1; idle(1); src[12] = 1'b0; idle(1);
      rd(a_clm(0), v); chk("R7 held in service", v, 0);
      wr(a_clm(0), 12); idle(2);
      chk("R7 captured edge", 32'(irq), 1);
      rd(a_clm(0), v); chk("R7 captured claim", v, 12);
      wr(a_clm(0), 12); idle(2);
      chk("R7 edges merged", 32'(irq), 0);
      rd(a_clm(0), v); chk("R7 nothing left", v, 0);
      // R3: routing to the second context
      wr(a_prio(20), 1); wr(a_en(1), 32'h0010_0000);
      rd(a_en(1), v); chk("R3 enable ctx1", v, 32'h0010_0000);
      src[20] = 1'b1; idle(2);
      chk("R3 ctx1 only", 32'(irq), 2);
      rd(a_clm(0), v); chk("R4 ctx0 empty", v, 0);
      rd(a_clm(1), v); chk("R4 ctx1 claim", v, 20);
      chk("R5 ctx1 low", 32'(irq), 0);
      wr(a_clm(1), 20); src[20] = 1'b0; idle(2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule